// File: doc/BRIEF.md
# Three-Period Bus Transfer Sequencer

This block is the processor-side master for single memory transfers on a parallel bus. The bus has a 16-bit address path and an 8-bit data path that the block either drives or samples. A request from the processor side is accepted only while the sequencer is idle. The sequencer then runs a fixed three-period transfer:

- **Address period:** the address goes out and neither strobe is active.
- **Strobe period:** the read or write strobe is raised. For a write, the block also drives its data onto the bus.
- **Completion period:** the strobe drops and a one-cycle done pulse is returned. For a read, the captured byte is returned at the same time.

The address is held on the bus for all three periods, so the responding memory always sees one location. The data-path drive enable controls an external tristate buffer. It is only raised for writes, so the memory owns the data lines during a read. While a transfer is in flight, a busy output tells the processor side that new requests are being dropped.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request (`req_i` high at a clock edge while `busy_o` is low) starts a transfer. In the following cycle (the address period), `busy_o` is high, `bus_addr_o` equals the requested address, and `bus_rd_o`, `bus_wr_o` and `bus_doe_o` are all low.
- R2: `bus_addr_o` does not change during the address, strobe and completion periods of a transfer.
- R3: For a read (`we_i` = 0), `bus_rd_o` is high only during the strobe period. The value on `bus_din_i` at the end of the strobe period appears on `rdata_o` during the completion period.
- R4: For a write (`we_i` = 1), `bus_wr_o` is high only during the strobe period, and `bus_dout_o` carries the write data there. `bus_doe_o` is high in both the strobe and the completion periods.
- R5: In the completion period both strobes are low and `done_o` is high for exactly that one cycle. The next cycle is idle with `busy_o` low.
- R6: `bus_rd_o` and `bus_wr_o` are never high together.
- R7: A request raised while `busy_o` is high is ignored. It does not change the address on the bus and does not start another transfer.
- R8: While `rst_n` is low, and until a request arrives after reset, `busy_o`, `done_o`, `bus_rd_o`, `bus_wr_o` and `bus_doe_o` are all low.
- R9: `bus_doe_o` is never high during a read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Transfer request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read, sampled with the request |
| addr_i | input | 16 | Transfer address |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Transfer in progress; requests are ignored |
| done_o | output | 1 | One-cycle pulse in the completion period |
| rdata_o | output | 8 | Captured read byte, valid with `done_o` on a read |
| bus_addr_o | output | 16 | Address lines |
| bus_dout_o | output | 8 | Data to the bus, meaningful while `bus_doe_o` is high |
| bus_doe_o | output | 1 | Data drive enable for the external tristate buffer |
| bus_rd_o | output | 1 | Active-high read strobe |
| bus_wr_o | output | 1 | Active-high write strobe |
| bus_din_i | input | 8 | Data lines as seen by the sequencer |

## Verification
The properties assume that the processor side samples `busy_o` before it trusts a request to be taken. They also assume that the memory presents valid data on `bus_din_i` by the end of the strobe period. No property constrains the data lines themselves, so stray values there cannot trip them.

The stimulus raises requests only at idle, except for deliberate mid-transfer pokes that exercise R7. Its memory model answers in the same cycle it sees the read strobe, which keeps within the zero-wait-state timing the design assumes.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_i,
  output logic   accept_o,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  assign accept_o = req_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept_o) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_STRB;
      PH_STRB: phase_d = PH_DONE;
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  phase_e            phase_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_din_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              cap_en;

  assign cap_en = (phase_i == PH_STRB) && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= bus_din_i;
  end

  assign we_o       = we_q;
  assign bus_addr_o = addr_q;
  assign bus_dout_o = wdata_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic              bus_doe_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  input  logic [DATA_W-1:0] bus_din_i
);
  logic   rst_sync_n;
  logic   accept;
  logic   we_q;
  phase_e phase;

  bcs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcs_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_i    (req_i),
    .accept_o (accept),
    .phase_o  (phase)
  );

  bcs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept_i   (accept),
    .phase_i    (phase),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .bus_din_i  (bus_din_i),
    .we_o       (we_q),
    .bus_addr_o (bus_addr_o),
    .bus_dout_o (bus_dout_o),
    .rdata_o    (rdata_o)
  );

  assign busy_o    = (phase != PH_IDLE);
  assign done_o    = (phase == PH_DONE);
  assign bus_rd_o  = (phase == PH_STRB) && !we_q;
  assign bus_wr_o  = (phase == PH_STRB) &&  we_q;
  assign bus_doe_o = we_q && ((phase == PH_STRB) || (phase == PH_DONE));
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_doe_o,
  input logic              bus_rd_o,
  input logic              bus_wr_o,
  input logic [DATA_W-1:0] bus_din_i
);
  logic unused_din;
  assign unused_din = ^bus_din_i;

  // R1: an accepted request opens the address period with strobes low
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o) |=> (busy_o && !bus_rd_o && !bus_wr_o && !bus_doe_o));

  // R2: address held from address period through completion
  a_r2_addr_hold_strb: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_o || bus_wr_o) |-> $stable(bus_addr_o));
  a_r2_addr_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $stable(bus_addr_o));

  // R3/R4: each strobe lasts a single period
  a_r3_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |=> (!bus_rd_o && done_o));
  a_r4_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |=> (!bus_wr_o && done_o && bus_doe_o));

  // R5: done follows a strobe and returns to idle
  a_r5_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bus_rd_o || bus_wr_o));
  a_r5_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R6: strobes exclusive
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));

  // R8: quiet bus while idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bus_rd_o && !bus_wr_o && !bus_doe_o && !done_o));

  // R9: no data drive while reading
  a_r9_no_doe_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |-> !bus_doe_o);
endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .bus_addr_o (bus_addr_o),
  .bus_doe_o  (bus_doe_o),
  .bus_rd_o   (bus_rd_o),
  .bus_wr_o   (bus_wr_o),
  .bus_din_i  (bus_din_i)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  logic        clk, rst_n, req_i, we_i;
  logic [15:0] addr_i, bus_addr_o;
  logic [7:0]  wdata_i, rdata_o, bus_dout_o, bus_din_i;
  logic        busy_o, done_o, bus_doe_o, bus_rd_o, bus_wr_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct packed { logic we; logic [15:0] addr; logic [7:0] data; } item_t;
  item_t exp_q[$];

  logic [7:0] mem     [0:255];
  logic [7:0] exp_mem [0:255];

  bus_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .bus_addr_o(bus_addr_o), .bus_dout_o(bus_dout_o), .bus_doe_o(bus_doe_o),
    .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .bus_din_i(bus_din_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // zero-wait memory responder
  assign bus_din_i = bus_rd_o ? mem[bus_addr_o[7:0]] : 8'h00;
  always @(posedge clk) if (bus_wr_o && bus_doe_o) mem[bus_addr_o[7:0]] <= bus_dout_o;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items on done
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected done", 32'd1, 32'd0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(bus_addr_o == it.addr, "R2 addr at completion", bus_addr_o, it.addr);
        if (it.we) chk(mem[it.addr[7:0]] == it.data, "R4 memory written", mem[it.addr[7:0]], it.data);
        else       chk(rdata_o == it.data, "R3 read data", rdata_o, it.data);
      end
    end
  end

  task automatic xfer(input bit we, input logic [15:0] a, input logic [7:0] d, input bit poke);
    item_t it;
    it.we = we; it.addr = a; it.data = we ? d : exp_mem[a[7:0]];
    if (we) exp_mem[a[7:0]] = d;
    exp_q.push_back(it);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; addr_i = ~a; wdata_i = ~d;
    chk(busy_o && !bus_rd_o && !bus_wr_o && !bus_doe_o, "R1 address period", {bus_rd_o,bus_wr_o,bus_doe_o,busy_o}, 4'b0001);
    chk(bus_addr_o == a, "R1 address", bus_addr_o, a);
    if (poke) begin req_i = 1'b1; we_i = ~we; addr_i = a ^ 16'h0F0F; end
    @(negedge clk);
    req_i = 1'b0;
    chk(bus_addr_o == a, "R2 addr strobe period", bus_addr_o, a);
    chk(!(bus_rd_o && bus_wr_o), "R6 exclusive strobes", {bus_rd_o,bus_wr_o}, 2'b00);
    if (we) begin
      chk(bus_wr_o && !bus_rd_o && bus_doe_o, "R4 write strobe", {bus_wr_o,bus_rd_o,bus_doe_o}, 3'b101);
      chk(bus_dout_o == d, "R4 write data", bus_dout_o, d);
    end else begin
      chk(bus_rd_o && !bus_wr_o, "R3 read strobe", {bus_rd_o,bus_wr_o}, 2'b10);
      chk(!bus_doe_o, "R9 no drive on read", bus_doe_o, 1'b0);
    end
    if (poke) req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(done_o && !bus_rd_o && !bus_wr_o, "R5 completion period", {done_o,bus_rd_o,bus_wr_o}, 3'b100);
    chk(bus_doe_o == we, "R4/R9 drive in completion", bus_doe_o, we);
    @(negedge clk);
    chk(!busy_o && !done_o, "R5 back to idle", {busy_o,done_o}, 2'b00);
    if (poke) begin
      @(negedge clk);
      chk(!busy_o && exp_q.size() == 0, "R7 poke ignored", busy_o, 1'b0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    rst_n = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !bus_rd_o && !bus_wr_o && !bus_doe_o, "R8 reset state",
        {busy_o,done_o,bus_rd_o,bus_wr_o,bus_doe_o}, 5'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !bus_doe_o, "R8 idle after reset", {busy_o,bus_doe_o}, 2'b00);

    xfer(1'b0, 16'h0010, 8'h00, 1'b0);
    xfer(1'b1, 16'h0010, 8'hA5, 1'b0);
    xfer(1'b0, 16'h0010, 8'h00, 1'b0);
    xfer(1'b1, 16'hFFFF, 8'h3C, 1'b1);
    xfer(1'b0, 16'hFFFF, 8'h00, 1'b1);
    xfer(1'b0, 16'h8001, 8'h00, 1'b0);
    for (int k = 0; k < 8; k++) xfer(k[0], 16'(k * 16'h1111), 8'(k * 29), 1'b0);
    // back-to-back: request on the idle cycle right after completion
    xfer(1'b1, 16'h0042, 8'h5A, 1'b0);
    xfer(1'b0, 16'h0042, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all transfers done", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule